// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 34-bit physical address by walking a two-level page table of 4-byte entries over 4 KiB pages. A request carries the virtual address, the access kind, the privilege of the requester and the root page number from the translation control register. It can also select bare mode, in which translation is switched off. The walker reads one table entry at a time over a simple request/acknowledge memory port. For each entry it decides whether the walk descends, completes or faults, and it reports a physical address or a fault code.

It keeps two fault kinds apart. An access fault means that an entry's address lies outside the physical memory window, and in that case the walker never issues the read. A page fault means that the table content forbids the access. A leaf entry found at the upper level maps a 4 MiB superpage and must be aligned to it. On a successful walk the walker sets the accessed bit in the leaf, and for a store it also sets the dirty bit. This takes one write to the same entry address, and the write is skipped when nothing would change. The permission rules sit in their own leaf-check module.

Top module: `ptw_walker`

## Requirements
- R1: With `req_bare` high, the response arrives in the cycle after acceptance with `rsp_paddr` equal to `req_vaddr` zero-extended to 34 bits and `rsp_fault` = 0, and no memory access is made.
- R2: The walk starts at base `req_root`<<12 and first reads the entry at base + vaddr[31:22]×4. A pointer entry (V=1, R=W=X=0) gives the next base as entry[31:10]<<12, and the walker then reads base + vaddr[21:12]×4. A leaf found at the lower level yields {entry[31:10], vaddr[11:0]}. Entry bits are V0 R1 W2 X3 U4 A6 D7, with the page number in [31:10].
- R3: A leaf found at the upper level yields {entry[31:20], vaddr[21:0]}. If entry[19:10] is nonzero, the leaf is a misaligned superpage and the result is a page fault.
- R4: If an entry address falls outside [MEM_BASE, MEM_BASE+MEM_SIZE), the result is an access fault (`rsp_fault` = 2) and that address is never placed on the memory port. Fault codes are 0 for none, 1 for page fault and 2 for access fault.
- R5: An entry with V=0, or with W=1 and R=0, gives a page fault.
- R6: A pointer entry found at the lower level gives a page fault.
- R7: Kind codes are 0 fetch, 1 load and 2 store. A fetch needs X. A load needs R, or X together with `req_mxr`. A store needs both R and W. Any other case is a page fault.
- R8: With `req_smode` = 1 (supervisor), a leaf with U=1 is refused for a fetch, and for a load or store unless `req_sum` is set. With `req_smode` = 0 (user), a leaf with U=0 is refused. A refusal is a page fault.
- R9: On success, if A is clear, or if the access is a store and D is clear, the walker makes exactly one write of the entry with A set (and D set for a store) to the leaf's address. Otherwise, and on any fault, it makes no write.
- R10: `req_ready` is high only when the walker is idle. `rsp_valid` is a single-cycle pulse. Once `mem_req` is raised, it stays high with a stable address and direction until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| req_smode | input | 1 | 1 supervisor, 0 user |
| req_sum | input | 1 | Supervisor may touch user pages for load/store |
| req_mxr | input | 1 | Execute-only pages readable by loads |
| req_bare | input | 1 | Translation off |
| req_root | input | 22 | Root table page number |
| rsp_valid | output | 1 | Result pulse |
| rsp_paddr | output | 34 | Physical address (0 on fault) |
| rsp_fault | output | 2 | 0 none, 1 page, 2 access |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 34 | Entry byte address |
| mem_wdata | output | 32 | Updated entry |
| mem_ack | input | 1 | Access complete, read data valid |
| mem_rdata | input | 32 | Read entry |

## Verification
The assertions check the port-level rules on every cycle. A memory request never targets an address outside the window or off word alignment, and it holds steady until acknowledged. Every write carries the accessed bit. A response lasts exactly one cycle, and a bare request is answered on the next cycle with no fault. Only the bench's scenarios can show that the walk reads the right entries and assembles the right address for both page sizes. The same holds for telling page faults from access faults, for each permission, privilege and mxr/sum combination, and for whether the accessed/dirty write happens or is skipped.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W      = 32;
  localparam int PA_W      = 34;
  localparam int PTE_W     = 32;
  localparam int PG_SHIFT  = 12;
  localparam int IDX_W     = 10;
  localparam int LEVELS    = 2;
  localparam int PTE_BYTES = 4;
  localparam int PPN_W     = PA_W - PG_SHIFT;
  localparam int PPN_LSB   = 10;
  localparam int LVL_W     = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int TOP_LVL   = LEVELS - 1;

  localparam int B_V = 0;
  localparam int B_R = 1;
  localparam int B_W = 2;
  localparam int B_X = 3;
  localparam int B_U = 4;
  localparam int B_A = 6;
  localparam int B_D = 7;

  typedef enum logic [1:0] {ACC_FETCH = 2'd0, ACC_LOAD = 2'd1, ACC_STORE = 2'd2} acc_e;
  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_PAGE = 2'd1, FLT_ACCESS = 2'd2} flt_e;

  // index field of the virtual address for a given level
  function automatic logic [IDX_W-1:0] vpn_at(logic [VA_W-1:0] va, logic [LVL_W-1:0] lvl);
    return va[PG_SHIFT + int'(lvl) * IDX_W +: IDX_W];
  endfunction

  // byte address of an entry inside the table at page ppn
  function automatic logic [PA_W-1:0] entry_addr(logic [PPN_W-1:0] ppn, logic [IDX_W-1:0] idx);
    return {ppn, {PG_SHIFT{1'b0}}} + PA_W'(idx) * PA_W'(PTE_BYTES);
  endfunction

  // physical address of a leaf: low virtual bits pass through for a superpage
  function automatic logic [PA_W-1:0] leaf_paddr(logic [PPN_W-1:0] ppn, logic [VA_W-1:0] va,
                                                 logic [LVL_W-1:0] lvl);
    logic [PA_W-1:0] keep;
    keep = (PA_W'(1) << (PG_SHIFT + int'(lvl) * IDX_W)) - PA_W'(1);
    return ({ppn, {PG_SHIFT{1'b0}}} & ~keep) | (PA_W'(va) & keep);
  endfunction

  function automatic logic in_window(logic [PA_W-1:0] a, logic [PA_W-1:0] base,
                                     logic [PA_W-1:0] size);
    return (a >= base) && ((a - base) < size);
  endfunction
endpackage

// File: rtl/ptw_addr.sv
module ptw_addr import ptw_pkg::*; #(
  parameter logic [PA_W-1:0] MEM_BASE = 34'h0_8000_0000,
  parameter logic [PA_W-1:0] MEM_SIZE = 34'h0_0100_0000
) (
  input  logic [PPN_W-1:0] base_ppn,
  input  logic [VA_W-1:0]  vaddr,
  input  logic [LVL_W-1:0] level,
  output logic [PA_W-1:0]  pte_addr,
  output logic             mapped
);
  always_comb begin
    pte_addr = entry_addr(base_ppn, vpn_at(vaddr, level));
    mapped   = in_window(pte_addr, MEM_BASE, MEM_SIZE);
  end
endmodule

// File: rtl/ptw_leaf.sv
module ptw_leaf import ptw_pkg::*; (
  input  logic [PTE_W-1:0] pte,
  input  logic [1:0]       kind,
  input  logic             smode,
  input  logic             sum,
  input  logic             mxr,
  input  logic [LVL_W-1:0] level,
  output logic             is_table,
  output logic             leaf_bad,
  output logic             needs_wb,
  output logic [PTE_W-1:0] pte_upd
);
  logic priv_bad, form_bad, type_bad, misalign;
  logic [PPN_W-1:0] ppn;
  logic [PPN_W-1:0] low_mask;

  always_comb begin
    ppn      = PPN_W'(pte[PTE_W-1:PPN_LSB]);
    low_mask = (PPN_W'(1) << (int'(level) * IDX_W)) - PPN_W'(1);
    is_table = pte[B_V] && !pte[B_R] && !pte[B_W] && !pte[B_X];
    priv_bad = pte[B_U] ? (smode && (acc_e'(kind) == ACC_FETCH || !sum)) : !smode;
    form_bad = !pte[B_V] || (!pte[B_R] && pte[B_W]);
    case (acc_e'(kind))
      ACC_FETCH: type_bad = !pte[B_X];
      ACC_LOAD:  type_bad = !(pte[B_R] || (mxr && pte[B_X]));
      default:   type_bad = !(pte[B_R] && pte[B_W]);
    endcase
    misalign = (ppn & low_mask) != '0;
    leaf_bad = priv_bad || form_bad || type_bad || misalign;
    pte_upd  = pte | (PTE_W'(1) << B_A)
                   | ((acc_e'(kind) == ACC_STORE) ? (PTE_W'(1) << B_D) : '0);
    needs_wb = pte_upd != pte;
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker import ptw_pkg::*; #(
  parameter logic [PA_W-1:0] MEM_BASE = 34'h0_8000_0000,
  parameter logic [PA_W-1:0] MEM_SIZE = 34'h0_0100_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic             req_smode,
  input  logic             req_sum,
  input  logic             req_mxr,
  input  logic             req_bare,
  input  logic [PPN_W-1:0] req_root,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_fault,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PA_W-1:0]  mem_addr,
  output logic [PTE_W-1:0] mem_wdata,
  input  logic             mem_ack,
  input  logic [PTE_W-1:0] mem_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_RESP} st_e;

  st_e              st;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       kind_q;
  logic             smode_q, sum_q, mxr_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PA_W-1:0]  addr_q;
  logic [PTE_W-1:0] wdata_q;
  logic [PA_W-1:0]  pa_q;
  flt_e             flt_q;

  // address generator inputs: request in idle, fetched pointer during a walk
  logic [PPN_W-1:0] ag_ppn;
  logic [VA_W-1:0]  ag_va;
  logic [LVL_W-1:0] ag_lvl;
  logic [PA_W-1:0]  ag_addr;
  logic             ag_mapped;

  logic             lf_table, lf_bad, lf_wb;
  logic [PTE_W-1:0] lf_upd;

  // named internal events
  logic ev_accept, ev_rd_done, ev_step, ev_bottom, ev_leaf_ok, ev_wr_done;

  always_comb begin
    if (st == S_IDLE) begin
      ag_ppn = req_root;
      ag_va  = req_vaddr;
      ag_lvl = LVL_W'(TOP_LVL);
    end else begin
      ag_ppn = PPN_W'(mem_rdata[PTE_W-1:PPN_LSB]);
      ag_va  = va_q;
      ag_lvl = LVL_W'(lvl_q - 1'b1);
    end
  end

  ptw_addr #(.MEM_BASE(MEM_BASE), .MEM_SIZE(MEM_SIZE)) u_addr (
    .base_ppn (ag_ppn),
    .vaddr    (ag_va),
    .level    (ag_lvl),
    .pte_addr (ag_addr),
    .mapped   (ag_mapped)
  );

  ptw_leaf u_leaf (
    .pte      (mem_rdata),
    .kind     (kind_q),
    .smode    (smode_q),
    .sum      (sum_q),
    .mxr      (mxr_q),
    .level    (lvl_q),
    .is_table (lf_table),
    .leaf_bad (lf_bad),
    .needs_wb (lf_wb),
    .pte_upd  (lf_upd)
  );

  assign ev_accept  = (st == S_IDLE) && req_valid;
  assign ev_rd_done = (st == S_READ) && !mem_we && mem_ack;
  assign ev_bottom  = lvl_q == '0;
  assign ev_step    = ev_rd_done && lf_table && !ev_bottom;
  assign ev_leaf_ok = ev_rd_done && !lf_table && !lf_bad;
  assign ev_wr_done = (st == S_WRITE) && mem_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va_q    <= '0;
      kind_q  <= '0;
      smode_q <= 1'b0;
      sum_q   <= 1'b0;
      mxr_q   <= 1'b0;
      lvl_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      pa_q    <= '0;
      flt_q   <= FLT_NONE;
    end else begin
      case (st)
        S_IDLE: if (ev_accept) begin
          va_q    <= req_vaddr;
          kind_q  <= req_kind;
          smode_q <= req_smode;
          sum_q   <= req_sum;
          mxr_q   <= req_mxr;
          lvl_q   <= LVL_W'(TOP_LVL);
          pa_q    <= '0;
          flt_q   <= FLT_NONE;
          if (req_bare) begin
            pa_q <= PA_W'(req_vaddr);
            st   <= S_RESP;
          end else if (!ag_mapped) begin
            flt_q <= FLT_ACCESS;
            st    <= S_RESP;
          end else begin
            addr_q <= ag_addr;
            st     <= S_READ;
          end
        end
        S_READ: if (ev_rd_done) begin
          if (lf_table) begin
            if (ev_bottom) begin
              flt_q <= FLT_PAGE;
              st    <= S_RESP;
            end else if (!ag_mapped) begin
              flt_q <= FLT_ACCESS;
              st    <= S_RESP;
            end else begin
              addr_q <= ag_addr;
              lvl_q  <= ag_lvl;
            end
          end else if (lf_bad) begin
            flt_q <= FLT_PAGE;
            st    <= S_RESP;
          end else begin
            pa_q <= leaf_paddr(PPN_W'(mem_rdata[PTE_W-1:PPN_LSB]), va_q, lvl_q);
            if (lf_wb) begin
              wdata_q <= lf_upd;
              st      <= S_WRITE;
            end else begin
              st <= S_RESP;
            end
          end
        end
        S_WRITE: if (ev_wr_done) st <= S_RESP;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = st == S_IDLE;
  assign rsp_valid = st == S_RESP;
  assign rsp_paddr = pa_q;
  assign rsp_fault = flt_q;
  assign mem_req   = (st == S_READ) || (st == S_WRITE);
  assign mem_we    = st == S_WRITE;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
endmodule

// File: rtl/ptw_sva.sv
module ptw_sva import ptw_pkg::*; #(
  parameter logic [PA_W-1:0] MEM_BASE = 34'h0_8000_0000,
  parameter logic [PA_W-1:0] MEM_SIZE = 34'h0_0100_0000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_bare,
  input logic             rsp_valid,
  input logic [1:0]       rsp_fault,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ack,
  input logic [PA_W-1:0]  mem_addr,
  input logic [PTE_W-1:0] mem_wdata
);
  AST_BARE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_bare) |=> (rsp_valid && rsp_fault == 2'd0)); // R1
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00)); // R2
  AST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((mem_addr >= MEM_BASE) && ((mem_addr - MEM_BASE) < MEM_SIZE))); // R4
  AST_WRITE_HAS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[B_A]); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10
  AST_RSP_QUIET_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!mem_req && !req_ready)); // R10
endmodule

bind ptw_walker ptw_sva #(.MEM_BASE(MEM_BASE), .MEM_SIZE(MEM_SIZE)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_bare  (req_bare),
  .rsp_valid (rsp_valid),
  .rsp_fault (rsp_fault),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata)
);

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;
  localparam logic [33:0] MBASE = 34'h0_8000_0000;
  localparam logic [33:0] MSIZE = 34'h0_0100_0000;
  localparam logic [21:0] ROOT  = 22'h80000;
  localparam logic [21:0] L0TB  = 22'h80001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_smode = 1'b1, req_sum = 1'b0, req_mxr = 1'b0, req_bare = 1'b0;
  logic [21:0] req_root = ROOT;
  logic        rsp_valid;
  logic [33:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        mem_req, mem_we;
  logic [33:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  ptw_walker #(.MEM_BASE(MBASE), .MEM_SIZE(MSIZE)) u0 (.*);

  logic [31:0] mem [logic [33:0]];
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] last_wdata = '0;
  int checks = 0, errors = 0, done_cnt = 0;

  typedef struct {
    string       tag;
    logic [1:0]  fault;
    logic [33:0] paddr;
    int          reads;
    int          writes;
    logic [31:0] wdata;
    int          rd_base;
    int          wr_base;
  } exp_t;
  exp_t sb[$];

  function automatic logic [31:0] peek(logic [33:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory model: acknowledges one cycle after a request is seen
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= peek(mem_addr);
    end else begin
      mem_ack <= 1'b0;
    end
    if (mem_req && mem_ack) begin
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        wr_cnt     <= wr_cnt + 1;
        last_wdata <= mem_wdata;
      end else begin
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic [21:0] ppn, logic [7:0] fl);
    return {ppn, 2'b00, fl};
  endfunction

  // reference walk written from the requirements
  function automatic exp_t model(string tag, logic [31:0] va, logic [1:0] k,
                                 logic sm, logic su, logic mx, logic bare, logic [21:0] root);
    exp_t e;
    logic [33:0] base, a;
    logic [31:0] p, np;
    int lvl;
    bit bad;
    e.tag = tag; e.fault = 2'd0; e.paddr = '0; e.reads = 0; e.writes = 0; e.wdata = '0;
    e.rd_base = 0; e.wr_base = 0;
    if (bare) begin e.paddr = {2'b00, va}; return e; end
    base = {root, 12'h000};
    lvl = 1;
    forever begin
      a = base + 34'((lvl == 1 ? va[31:22] : va[21:12])) * 34'd4;
      if (!(a >= MBASE && a - MBASE < MSIZE)) begin e.fault = 2'd2; return e; end
      e.reads++;
      p = peek(a);
      if (p[0] && p[3:1] == 3'b000) begin
        if (lvl == 0) begin e.fault = 2'd1; return e; end
        base = {p[31:10], 12'h000};
        lvl = 0;
        continue;
      end
      bad = 1'b0;
      if (p[4]) bad |= sm && (k == 2'd0 || !su); else bad |= !sm;
      if (!p[0] || (!p[1] && p[2])) bad = 1'b1;
      if (k == 2'd0) bad |= !p[3];
      else if (k == 2'd1) bad |= !(p[1] || (mx && p[3]));
      else bad |= !(p[1] && p[2]);
      if (lvl == 1 && p[19:10] != 10'h0) bad = 1'b1;
      if (bad) begin e.fault = 2'd1; return e; end
      e.paddr = (lvl == 1) ? {p[31:20], va[21:0]} : {p[31:10], va[11:0]};
      np = p | 32'h40 | ((k == 2'd2) ? 32'h80 : 32'h0);
      if (np != p) begin e.writes = 1; e.wdata = np; end
      return e;
    end
  endfunction

  task automatic run(string tag, logic [31:0] va, logic [1:0] k, logic sm, logic su,
                     logic mx, logic bare, logic [21:0] root);
    exp_t e;
    e = model(tag, va, k, sm, su, mx, bare, root);
    e.rd_base = rd_cnt;
    e.wr_base = wr_cnt;
    sb.push_back(e);
    @(negedge clk);
    req_vaddr = va; req_kind = k; req_smode = sm; req_sum = su; req_mxr = mx;
    req_bare = bare; req_root = root; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait (done_cnt == checks_issued + 1);
    checks_issued++;
  endtask
  int checks_issued = 0;

  // monitor: pops the scoreboard on every response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      exp_t e;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected response actual=1 expected=0");
      end else begin
        e = sb.pop_front();
        chk({e.tag, " fault"}, 64'(rsp_fault), 64'(e.fault));
        if (e.fault == 2'd0) chk({e.tag, " paddr"}, 64'(rsp_paddr), 64'(e.paddr));
        chk({e.tag, " reads"}, 64'(rd_cnt - e.rd_base), 64'(e.reads));
        chk({e.tag, " writes R9"}, 64'(wr_cnt - e.wr_base), 64'(e.writes));
        if (e.writes == 1) chk({e.tag, " wdata R9"}, 64'(last_wdata), 64'(e.wdata));
      end
      done_cnt++;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // root table entries (index = vaddr[31:22])
    mem[{ROOT, 12'h0} + 34'd4]  = mk(L0TB, 8'h01);          // pointer
    mem[{ROOT, 12'h0} + 34'd8]  = mk(22'h12C00, 8'h43);     // aligned superpage R|A
    mem[{ROOT, 12'h0} + 34'd12] = mk(22'h12C01, 8'h43);     // misaligned superpage
    mem[{ROOT, 12'h0} + 34'd16] = mk(22'h00010, 8'h01);     // pointer out of memory
    mem[{ROOT, 12'h0} + 34'd20] = mk(22'h12345, 8'h42);     // V clear
    // level-0 entries
    mem[{L0TB, 12'h0} + 34'd0]  = mk(22'h12345, 8'hC7);     // R|W|A|D
    mem[{L0TB, 12'h0} + 34'd4]  = mk(22'h23456, 8'h07);     // R|W, no A
    mem[{L0TB, 12'h0} + 34'd8]  = mk(22'h34567, 8'h49);     // X|A
    mem[{L0TB, 12'h0} + 34'd12] = mk(22'h45678, 8'h43);     // R|A
    mem[{L0TB, 12'h0} + 34'd16] = mk(22'h11111, 8'h06);     // V clear
    mem[{L0TB, 12'h0} + 34'd20] = mk(22'h11111, 8'h05);     // W without R
    mem[{L0TB, 12'h0} + 34'd24] = mk(22'h11111, 8'h01);     // pointer at bottom
    mem[{L0TB, 12'h0} + 34'd28] = mk(22'h56789, 8'hDF);     // U|X|W|R|A|D
    mem[{L0TB, 12'h0} + 34'd32] = mk(22'h6789A, 8'h47);     // R|W|A, D clear

    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset ready", 64'(req_ready), 64'd1);
    chk("R10 reset rsp", 64'(rsp_valid), 64'd0);
    chk("R10 reset mem_req", 64'(mem_req), 64'd0);

    run("R1 bare",               32'hDEADBEEF, 2'd1, 1, 0, 0, 1, ROOT);
    run("R2 4K load",            32'h00400ABC, 2'd1, 1, 0, 0, 0, ROOT);
    run("R9 store sets A D",     32'h00401010, 2'd2, 1, 0, 0, 0, ROOT);
    run("R9 repeat no write",    32'h00401020, 2'd2, 1, 0, 0, 0, ROOT);
    run("R7 fetch X",            32'h00402FFC, 2'd0, 1, 0, 0, 0, ROOT);
    run("R7 load X mxr0",        32'h00402000, 2'd1, 1, 0, 0, 0, ROOT);
    run("R7 load X mxr1",        32'h00402000, 2'd1, 1, 0, 1, 0, ROOT);
    run("R7 store on R",         32'h00403000, 2'd2, 1, 0, 0, 0, ROOT);
    run("R5 V clear",            32'h00404000, 2'd1, 1, 0, 0, 0, ROOT);
    run("R5 W no R",             32'h00405000, 2'd1, 1, 0, 0, 0, ROOT);
    run("R6 pointer at bottom",  32'h00406000, 2'd1, 1, 0, 0, 0, ROOT);
    run("R8 sup U sum0",         32'h00407000, 2'd1, 1, 0, 0, 0, ROOT);
    run("R8 sup U sum1",         32'h00407004, 2'd1, 1, 1, 0, 0, ROOT);
    run("R8 sup fetch U sum1",   32'h00407008, 2'd0, 1, 1, 0, 0, ROOT);
    run("R8 user U",             32'h0040700C, 2'd1, 0, 0, 0, 0, ROOT);
    run("R8 user non-U",         32'h00400000, 2'd1, 0, 0, 0, 0, ROOT);
    run("R9 store D clear",      32'h00408000, 2'd2, 1, 0, 0, 0, ROOT);
    run("R3 superpage",          32'h0089ABCD, 2'd1, 1, 0, 0, 0, ROOT);
    run("R3 misaligned",         32'h00C00000, 2'd1, 1, 0, 0, 0, ROOT);
    run("R4 pointer outside",    32'h01000000, 2'd1, 1, 0, 0, 0, ROOT);
    run("R4 root outside",       32'h00400000, 2'd1, 1, 0, 0, 0, 22'h00001);
    run("R5 V clear upper",      32'h01400000, 2'd1, 1, 0, 0, 0, ROOT);

    repeat (4) @(negedge clk);
    chk("R10 idle after runs", 64'(req_ready), 64'd1);
    chk("R10 scoreboard drained", 64'(sb.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule